// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block generates the source and destination byte addresses for a single DMA channel. A transfer is a block of frames, and each frame is a run of elements. A load strobe captures the channel's setup. That setup is the two start addresses, the element and frame totals, the element size code, a per-side addressing mode, the signed index registers, and the fill and transparency controls. After the load, each accepted transfer strobe moves both addresses on by one element step. At a frame boundary each address also gets its frame step.

The block reports its progress through single-cycle event pulses: half-frame, end-of-frame, last-frame and end-of-block. It also exports the low half of the destination address as a progress counter. A small write path sits beside the address logic. Constant fill replaces the read data with a captured 32-bit colour and turns off the source read. Transparent copy suppresses the write when the data equals the colour. The bus master that performs the reads and writes sits outside this block.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, busy, every event pulse, bad_req, both addresses and the progress counter read zero.
- R2: A valid load (element total and frame total both non-zero, size code not 3) sets busy one cycle later. It puts the source and destination start addresses on the address outputs and mirrors destination address bits 15:0 on the progress output.
- R3: Mode code 0 (constant) keeps a side's address unchanged on every element and frame step.
- R4: Mode code 1 (post-increment) advances a side by the element size on each accepted strobe. Size codes 0, 1 and 2 select 1, 2 and 4 bytes.
- R5: Mode code 2 (single index) advances a side on each element by size + element index − 1. The element index is a signed 16-bit value.
- R6: Mode code 3 (double index) uses the R5 element step. On the element that completes a frame it also adds frame index − element index, where both indexes are signed 16-bit values.
- R7: With compat_i high at load, the destination uses the source element and frame indexes. With compat_i low, the destination uses its own pair.
- R8: A load with a zero element total, a zero frame total or size code 3 pulses bad_req for one cycle. It leaves busy, both addresses and the counters untouched.
- R9: half_frame pulses after the strobe whose element number within the frame (counting from 1) equals the element total shifted right by one.
- R10: last_frame pulses after the strobe that moves the first element of the final frame.
- R11: end_frame pulses after the last element of every frame. end_block pulses with the final end_frame, and busy drops in the same cycle. Strobes while busy is low change nothing.
- R12: With constant fill captured at load, wr_data equals the colour and src_rd_en stays low on accepted strobes.
- R13: With transparent copy captured at load, wr_en stays low on a strobe whose write data equals the colour, and is high otherwise.
- R14: A valid load while busy restarts the transfer: both addresses return to the new start values, the element and frame counts restart, and that cycle's strobe produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture the setup and start a transfer |
| step_i | input | 1 | One element transfer strobe |
| compat_i | input | 1 | Destination shares the source index pair |
| src_mode_i | input | 2 | Source addressing mode (0 const, 1 post-inc, 2 single, 3 double) |
| dst_mode_i | input | 2 | Destination addressing mode |
| size_code_i | input | 2 | Element size code, bytes = 1 << code; 3 illegal |
| elem_total_i | input | 16 | Elements per frame |
| frame_total_i | input | 16 | Frames per block |
| src_start_i | input | 32 | Source start address |
| dst_start_i | input | 32 | Destination start address |
| src_eidx_i | input | 16 | Source element index, signed |
| src_fidx_i | input | 16 | Source frame index, signed |
| dst_eidx_i | input | 16 | Destination element index, signed |
| dst_fidx_i | input | 16 | Destination frame index, signed |
| fill_i | input | 1 | Constant fill enable |
| tcopy_i | input | 1 | Transparent copy enable |
| color_i | input | 32 | Fill / transparency colour |
| rd_data_i | input | 32 | Data read from the source |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| progress_o | output | 16 | Destination address bits 15:0 |
| busy_o | output | 1 | Transfer in progress |
| bad_req_o | output | 1 | Load rejected (pulse) |
| src_rd_en_o | output | 1 | Source read needed for this strobe |
| wr_en_o | output | 1 | Destination write for this strobe |
| wr_data_o | output | 32 | Data to write |
| half_frame_o | output | 1 | Half-frame event pulse |
| end_frame_o | output | 1 | End-of-frame event pulse |
| last_frame_o | output | 1 | Last-frame event pulse |
| end_block_o | output | 1 | End-of-block event pulse |

## Verification
The bench targets the frame boundary under double indexing with a negative element index. A design that sign-extended wrongly, or applied the frame step on the wrong element, would put every later address off by a constant. It runs compatibility mode with deliberately different destination indexes, so a design that ignored compat_i would give a distinct destination sequence. Rejected loads are issued straight after a finished block, so a rejected load that started a transfer would raise busy or move the addresses. The tests also cover a strobe after end of block, and a reload in the middle of a frame where stale counters would fire events early. Strobes carrying data equal to the colour check that transparency gates the write.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    AM_CONST  = 2'd0,
    AM_POST   = 2'd1,
    AM_SINGLE = 2'd2,
    AM_DOUBLE = 2'd3
  } addr_mode_e;

  typedef struct packed {
    logic block;
    logic last;
    logic frame;
    logic half;
  } evt_t;

endpackage

// File: rtl/dma2d_delta.sv
module dma2d_delta
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  addr_mode_e         mode_i,
  input  logic [2:0]         size_i,
  input  logic [IW-1:0]      eidx_i,
  input  logic [IW-1:0]      fidx_i,
  output logic [AW-1:0]      elem_delta_o,
  output logic [AW-1:0]      frame_delta_o
);

  localparam int EXT = AW - IW;

  logic [AW-1:0] size_w;
  logic [AW-1:0] eidx_w;
  logic [AW-1:0] fidx_w;

  assign size_w = {{(AW-3){1'b0}}, size_i};
  assign eidx_w = {{EXT{eidx_i[IW-1]}}, eidx_i};
  assign fidx_w = {{EXT{fidx_i[IW-1]}}, fidx_i};

  always_comb begin
    elem_delta_o  = '0;
    frame_delta_o = '0;
    case (mode_i)
      AM_CONST: begin
        elem_delta_o  = '0;
        frame_delta_o = '0;
      end
      AM_POST: begin
        elem_delta_o  = size_w;
      end
      AM_SINGLE: begin
        elem_delta_o  = size_w + eidx_w - AW'(1);
      end
      AM_DOUBLE: begin
        elem_delta_o  = size_w + eidx_w - AW'(1);
        frame_delta_o = fidx_w - eidx_w;
      end
      default: begin
        elem_delta_o  = '0;
        frame_delta_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          load_ok_i,
  input  logic          step_i,
  input  logic [CW-1:0] elem_total_i,
  input  logic [CW-1:0] frame_total_i,
  output logic          busy_o,
  output logic          adv_o,
  output logic          wrap_o,
  output evt_t          evt_o
);

  logic [CW-1:0] elem_q, elem_n;
  logic [CW-1:0] frm_q, frm_n;
  logic [CW-1:0] etot_q, etot_n;
  logic [CW-1:0] ftot_q, ftot_n;
  logic          busy_q, busy_n;
  evt_t          evt_q, evt_n;
  logic [CW-1:0] elem_inc;
  logic [CW-1:0] frm_inc;

  assign adv_o    = step_i && busy_q && !load_i;
  assign elem_inc = elem_q + CW'(1);
  assign frm_inc  = frm_q + CW'(1);
  assign wrap_o   = (elem_inc == etot_q);

  always_comb begin
    elem_n = elem_q;
    frm_n  = frm_q;
    etot_n = etot_q;
    ftot_n = ftot_q;
    busy_n = busy_q;
    evt_n  = '0;
    if (load_ok_i) begin
      elem_n = '0;
      frm_n  = '0;
      etot_n = elem_total_i;
      ftot_n = frame_total_i;
      busy_n = 1'b1;
    end else if (adv_o) begin
      evt_n.half  = (elem_inc == (etot_q >> 1));
      evt_n.last  = (elem_inc == CW'(1)) && (frm_q == ftot_q - CW'(1));
      evt_n.frame = wrap_o;
      if (wrap_o) begin
        elem_n = '0;
        frm_n  = frm_inc;
        if (frm_inc == ftot_q) begin
          evt_n.block = 1'b1;
          busy_n      = 1'b0;
        end
      end else begin
        elem_n = elem_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      frm_q  <= '0;
      etot_q <= '0;
      ftot_q <= '0;
      busy_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      elem_q <= elem_n;
      frm_q  <= frm_n;
      etot_q <= etot_n;
      ftot_q <= ftot_n;
      busy_q <= busy_n;
      evt_q  <= evt_n;
    end
  end

  assign busy_o = busy_q;
  assign evt_o  = evt_q;

endmodule

// File: rtl/dma2d_wpath.sv
module dma2d_wpath #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ok_i,
  input  logic          fill_i,
  input  logic          tcopy_i,
  input  logic [DW-1:0] color_i,
  input  logic          adv_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o
);

  logic          fill_q, fill_n;
  logic          tcopy_q, tcopy_n;
  logic [DW-1:0] color_q, color_n;

  always_comb begin
    fill_n  = fill_q;
    tcopy_n = tcopy_q;
    color_n = color_q;
    if (load_ok_i) begin
      fill_n  = fill_i;
      tcopy_n = tcopy_i;
      color_n = color_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= 1'b0;
      tcopy_q <= 1'b0;
      color_q <= '0;
    end else begin
      fill_q  <= fill_n;
      tcopy_q <= tcopy_n;
      color_q <= color_n;
    end
  end

  assign wr_data_o = fill_q ? color_q : rd_data_i;
  assign rd_en_o   = adv_i && !fill_q;
  assign wr_en_o   = adv_i && !(tcopy_q && (wr_data_o == color_q));

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          compat_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic [1:0]    size_code_i,
  input  logic [CW-1:0] elem_total_i,
  input  logic [CW-1:0] frame_total_i,
  input  logic [AW-1:0] src_start_i,
  input  logic [AW-1:0] dst_start_i,
  input  logic [IW-1:0] src_eidx_i,
  input  logic [IW-1:0] src_fidx_i,
  input  logic [IW-1:0] dst_eidx_i,
  input  logic [IW-1:0] dst_fidx_i,
  input  logic          fill_i,
  input  logic          tcopy_i,
  input  logic [DW-1:0] color_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic [PW-1:0] progress_o,
  output logic          busy_o,
  output logic          bad_req_o,
  output logic          src_rd_en_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic          half_frame_o,
  output logic          end_frame_o,
  output logic          last_frame_o,
  output logic          end_block_o
);

  localparam int NSIDE = 2;

  logic       load_ok;
  logic       bad_n, bad_q;
  logic       adv;
  logic       wrap;
  evt_t       evt;
  logic [2:0] size_bytes;

  logic [NSIDE-1:0][1:0]    side_mode;
  logic [NSIDE-1:0][IW-1:0] side_eidx;
  logic [NSIDE-1:0][IW-1:0] side_fidx;
  logic [NSIDE-1:0][AW-1:0] side_start;
  logic [NSIDE-1:0][AW-1:0] side_addr;

  assign load_ok    = load_i && (elem_total_i != '0) && (frame_total_i != '0)
                      && (size_code_i != 2'd3);
  assign bad_n      = load_i && !load_ok;
  assign size_bytes = 3'd1 << size_code_i;

  assign side_mode[0]  = src_mode_i;
  assign side_mode[1]  = dst_mode_i;
  assign side_eidx[0]  = src_eidx_i;
  assign side_fidx[0]  = src_fidx_i;
  assign side_eidx[1]  = compat_i ? src_eidx_i : dst_eidx_i;
  assign side_fidx[1]  = compat_i ? src_fidx_i : dst_fidx_i;
  assign side_start[0] = src_start_i;
  assign side_start[1] = dst_start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_n;
  end

  dma2d_seq #(.CW(CW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .load_ok_i    (load_ok),
    .step_i       (step_i),
    .elem_total_i (elem_total_i),
    .frame_total_i(frame_total_i),
    .busy_o       (busy_o),
    .adv_o        (adv),
    .wrap_o       (wrap),
    .evt_o        (evt)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic [AW-1:0] ed_calc, fd_calc;
    logic [AW-1:0] ed_q, ed_n;
    logic [AW-1:0] fd_q, fd_n;
    logic [AW-1:0] addr_q, addr_n;

    dma2d_delta #(.AW(AW), .IW(IW)) u_delta (
      .mode_i       (addr_mode_e'(side_mode[s])),
      .size_i       (size_bytes),
      .eidx_i       (side_eidx[s]),
      .fidx_i       (side_fidx[s]),
      .elem_delta_o (ed_calc),
      .frame_delta_o(fd_calc)
    );

    always_comb begin
      ed_n   = ed_q;
      fd_n   = fd_q;
      addr_n = addr_q;
      if (load_ok) begin
        ed_n   = ed_calc;
        fd_n   = fd_calc;
        addr_n = side_start[s];
      end else if (adv) begin
        addr_n = addr_q + ed_q + (wrap ? fd_q : '0);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ed_q   <= '0;
        fd_q   <= '0;
        addr_q <= '0;
      end else begin
        ed_q   <= ed_n;
        fd_q   <= fd_n;
        addr_q <= addr_n;
      end
    end

    assign side_addr[s] = addr_q;
  end

  dma2d_wpath #(.DW(DW)) u_wpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ok_i(load_ok),
    .fill_i   (fill_i),
    .tcopy_i  (tcopy_i),
    .color_i  (color_i),
    .adv_i    (adv),
    .rd_data_i(rd_data_i),
    .rd_en_o  (src_rd_en_o),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o)
  );

  assign src_addr_o   = side_addr[0];
  assign dst_addr_o   = side_addr[1];
  assign progress_o   = side_addr[1][PW-1:0];
  assign bad_req_o    = bad_q;
  assign half_frame_o = evt.half;
  assign end_frame_o  = evt.frame;
  assign last_frame_o = evt.last;
  assign end_block_o  = evt.block;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic          step_i,
  input logic          busy_o,
  input logic          bad_req_o,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o,
  input logic          half_frame_o,
  input logic          end_frame_o,
  input logic          last_frame_o,
  input logic          end_block_o
);

  AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_req_o && !$past(busy_o)) |-> !busy_o); // R8

  AST_BLOCK_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_block_o |-> !busy_o); // R11

  AST_BLOCK_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    end_block_o |-> end_frame_o); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o))); // R11

  AST_EVT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_frame_o || end_frame_o || last_frame_o) |-> $past(step_i)); // R9

  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(load_i)) |->
      !(half_frame_o || end_frame_o || last_frame_o || end_block_o)); // R14

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .step_i      (step_i),
  .busy_o      (busy_o),
  .bad_req_o   (bad_req_o),
  .src_addr_o  (src_addr_o),
  .dst_addr_o  (dst_addr_o),
  .half_frame_o(half_frame_o),
  .end_frame_o (end_frame_o),
  .last_frame_o(last_frame_o),
  .end_block_o (end_block_o)
);

// File: tb/dma2d_addr_gen_test.sv
`timescale 1ns/1ps
module dma2d_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, step_i, compat_i;
  logic [1:0]  src_mode_i, dst_mode_i, size_code_i;
  logic [15:0] elem_total_i, frame_total_i;
  logic [31:0] src_start_i, dst_start_i;
  logic [15:0] src_eidx_i, src_fidx_i, dst_eidx_i, dst_fidx_i;
  logic        fill_i, tcopy_i;
  logic [31:0] color_i, rd_data_i;
  logic [31:0] src_addr_o, dst_addr_o, wr_data_o;
  logic [15:0] progress_o;
  logic        busy_o, bad_req_o, src_rd_en_o, wr_en_o;
  logic        half_frame_o, end_frame_o, last_frame_o, end_block_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i), .compat_i(compat_i),
    .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i), .size_code_i(size_code_i),
    .elem_total_i(elem_total_i), .frame_total_i(frame_total_i),
    .src_start_i(src_start_i), .dst_start_i(dst_start_i),
    .src_eidx_i(src_eidx_i), .src_fidx_i(src_fidx_i),
    .dst_eidx_i(dst_eidx_i), .dst_fidx_i(dst_fidx_i),
    .fill_i(fill_i), .tcopy_i(tcopy_i), .color_i(color_i), .rd_data_i(rd_data_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .progress_o(progress_o),
    .busy_o(busy_o), .bad_req_o(bad_req_o), .src_rd_en_o(src_rd_en_o),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .half_frame_o(half_frame_o), .end_frame_o(end_frame_o),
    .last_frame_o(last_frame_o), .end_block_o(end_block_o)
  );

  // bench model of the transfer in progress
  logic [31:0] m_src, m_dst, m_sed, m_sfd, m_ded, m_dfd;
  int m_e, m_f, m_et, m_ft;
  bit m_busy;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic void calc_delta(input logic [1:0] mode, input logic [1:0] code,
                                     input logic [15:0] ei, input logic [15:0] fi,
                                     output logic [31:0] ed, output logic [31:0] fd);
    int sz = 1 << code;
    int e  = int'($signed(ei));
    int f  = int'($signed(fi));
    case (mode)
      2'd0: begin ed = 0; fd = 0; end                 // R3
      2'd1: begin ed = sz; fd = 0; end                // R4
      2'd2: begin ed = sz + e - 1; fd = 0; end        // R5
      default: begin ed = sz + e - 1; fd = f - e; end // R6
    endcase
  endfunction

  task automatic do_load();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic load_valid(string req);
    logic [15:0] de, df;
    de = compat_i ? src_eidx_i : dst_eidx_i; // R7
    df = compat_i ? src_fidx_i : dst_fidx_i;
    calc_delta(src_mode_i, size_code_i, src_eidx_i, src_fidx_i, m_sed, m_sfd);
    calc_delta(dst_mode_i, size_code_i, de, df, m_ded, m_dfd);
    m_src = src_start_i; m_dst = dst_start_i;
    m_e = 0; m_f = 0; m_et = elem_total_i; m_ft = frame_total_i; m_busy = 1;
    do_load();
    check(req, "busy after load", {31'd0, busy_o}, 32'd1);
    check(req, "src start", src_addr_o, m_src);
    check(req, "dst start", dst_addr_o, m_dst);
    check(req, "progress", {16'd0, progress_o}, {16'd0, m_dst[15:0]});
  endtask

  task automatic step_check(string req);
    bit half, last, ef, eb;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    half = 0; last = 0; ef = 0; eb = 0;
    if (m_busy) begin
      m_e++;
      half = (m_e == (m_et >> 1));
      last = (m_e == 1) && (m_f == m_ft - 1);
      ef   = (m_e == m_et);
      m_src = m_src + m_sed;
      m_dst = m_dst + m_ded;
      if (ef) begin
        m_src = m_src + m_sfd;
        m_dst = m_dst + m_dfd;
        m_e = 0; m_f++;
        if (m_f == m_ft) begin eb = 1; m_busy = 0; end
      end
    end
    check(req, "src addr", src_addr_o, m_src);
    check(req, "dst addr", dst_addr_o, m_dst);
    check(req, "progress", {16'd0, progress_o}, {16'd0, m_dst[15:0]});
    check("R9", "half_frame", {31'd0, half_frame_o}, {31'd0, half});
    check("R10", "last_frame", {31'd0, last_frame_o}, {31'd0, last});
    check("R11", "end_frame", {31'd0, end_frame_o}, {31'd0, ef});
    check("R11", "end_block", {31'd0, end_block_o}, {31'd0, eb});
    check("R11", "busy", {31'd0, busy_o}, {31'd0, m_busy});
  endtask

  task automatic set_defaults();
    load_i = 0; step_i = 0; compat_i = 0;
    src_mode_i = 2'd1; dst_mode_i = 2'd1; size_code_i = 2'd0;
    elem_total_i = 16'd4; frame_total_i = 16'd2;
    src_start_i = 32'h0000_1000; dst_start_i = 32'h0000_2000;
    src_eidx_i = 0; src_fidx_i = 0; dst_eidx_i = 0; dst_fidx_i = 0;
    fill_i = 0; tcopy_i = 0; color_i = 0; rd_data_i = 0;
  endtask

  task automatic test_reset();
    check("R1", "busy", {31'd0, busy_o}, 0);
    check("R1", "src addr", src_addr_o, 0);
    check("R1", "dst addr", dst_addr_o, 0);
    check("R1", "progress", {16'd0, progress_o}, 0);
    check("R1", "events", {28'd0, half_frame_o, end_frame_o, last_frame_o, end_block_o}, 0);
    check("R1", "bad_req", {31'd0, bad_req_o}, 0);
  endtask

  task automatic test_post_inc();
    for (int c = 0; c < 3; c++) begin
      set_defaults();
      size_code_i = c[1:0];
      src_start_i = 32'h0001_0000 + 32'(c);
      dst_start_i = 32'h0002_fff0;
      load_valid("R2");
      for (int k = 0; k < 8; k++) step_check("R4");
      step_check("R11"); // strobe after end of block is ignored
    end
  endtask

  task automatic test_const_single();
    set_defaults();
    src_mode_i = 2'd0; dst_mode_i = 2'd2; size_code_i = 2'd1;
    dst_eidx_i = 16'hfffd; // -3
    elem_total_i = 3; frame_total_i = 2;
    dst_start_i = 32'h0000_0100;
    load_valid("R3");
    for (int k = 0; k < 6; k++) step_check("R5");
  endtask

  task automatic test_double();
    set_defaults();
    src_mode_i = 2'd3; dst_mode_i = 2'd3; size_code_i = 2'd0;
    src_eidx_i = 16'd3; src_fidx_i = 16'd10;
    dst_eidx_i = 16'hfffe; dst_fidx_i = 16'hff00;
    elem_total_i = 3; frame_total_i = 3;
    compat_i = 1'b1;
    load_valid("R7");
    for (int k = 0; k < 9; k++) step_check("R6");
    compat_i = 1'b0;
    elem_total_i = 2; frame_total_i = 2; size_code_i = 2'd2;
    load_valid("R7");
    for (int k = 0; k < 4; k++) step_check("R6");
  endtask

  task automatic test_bad();
    logic [31:0] s0, d0;
    for (int c = 0; c < 3; c++) begin
      set_defaults();
      if (c == 0) elem_total_i = 0;
      if (c == 1) frame_total_i = 0;
      if (c == 2) size_code_i = 2'd3;
      src_start_i = 32'hdead_0000; dst_start_i = 32'hbeef_0000;
      s0 = src_addr_o; d0 = dst_addr_o;
      do_load();
      check("R8", "bad_req pulse", {31'd0, bad_req_o}, 1);
      check("R8", "busy", {31'd0, busy_o}, 0);
      check("R8", "src addr", src_addr_o, s0);
      check("R8", "dst addr", dst_addr_o, d0);
      @(negedge clk);
      check("R8", "bad_req one cycle", {31'd0, bad_req_o}, 0);
    end
  endtask

  task automatic test_fill_tcopy();
    set_defaults();
    fill_i = 1; color_i = 32'ha5a5_5a5a; rd_data_i = 32'h1234_5678;
    load_valid("R12");
    step_i = 1; #1;
    check("R12", "wr_data is colour", wr_data_o, 32'ha5a5_5a5a);
    check("R12", "no source read", {31'd0, src_rd_en_o}, 0);
    check("R12", "write enabled", {31'd0, wr_en_o}, 1);
    step_i = 0;
    set_defaults();
    tcopy_i = 1; color_i = 32'h0000_00ff; rd_data_i = 32'h0000_00ff;
    load_valid("R13");
    step_i = 1; #1;
    check("R13", "write suppressed", {31'd0, wr_en_o}, 0);
    check("R13", "source read", {31'd0, src_rd_en_o}, 1);
    rd_data_i = 32'h0000_00fe; #1;
    check("R13", "write passes", {31'd0, wr_en_o}, 1);
    check("R13", "wr_data", wr_data_o, 32'h0000_00fe);
    step_i = 0;
    @(negedge clk);
  endtask

  task automatic test_reload();
    set_defaults();
    elem_total_i = 4; frame_total_i = 1;
    load_valid("R14");
    step_check("R14");
    src_start_i = 32'h0000_8000; dst_start_i = 32'h0000_9000;
    elem_total_i = 2; frame_total_i = 1;
    step_i = 1; // strobe coincides with reload
    load_valid("R14");
    step_i = 0;
    check("R14", "no event on reload",
          {28'd0, half_frame_o, end_frame_o, last_frame_o, end_block_o}, 0);
    step_check("R14");
    step_check("R14");
  endtask

  initial begin
    set_defaults();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_post_inc();
    test_const_single();
    test_double();
    test_bad();
    test_fill_tcopy();
    test_reload();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule